// File: doc/BRIEF.md
# Shared Video/CPU Memory Interleaver

This block lets a processor and a raster video fetcher use one static RAM with no wait states and no screen disturbance. Every processor bus cycle is cut into two halves, and both halves are timed from a single master clock by an integer divider. During the first half (phase 1) the video fetcher owns the RAM. Its address is driven out and the returned byte is captured at the last master clock of the half. During the second half (phase 2) the processor owns the RAM: its address, write data and write enable reach the memory only then. Because the processor clock runs at the video fetch rate, the two masters alternate every cycle and the processor never waits for blanking.

A strap input picks the cycle length. Low selects the PAL divider (about 1.77 MHz from a carrier-related master clock) and high selects the NTSC divider (about 1.79 MHz). The strap is taken only at a cycle boundary. Processor addresses are decoded by mask and base comparison into RAM, ROM and I/O regions, and unused address bits are ignored. Write data travels out on a bus of its own. Read data comes back through a separate multiplexer that selects among RAM, ROM and I/O, and returns a fixed open-bus value when nothing is mapped.

Top module: `mem_interleave`

## Requirements
- R1: A processor cycle lasts 2*HALF_PAL master clocks when `ntsc_i` is 0 and 2*HALF_NTSC when it is 1. The strap is sampled only on the clock edge that starts a new cycle.
- R2: Phase 1 covers the first half of each cycle and phase 2 the second half. The two are never high together. Both stay low in reset and until the first clock edge after reset.
- R3: `ram_addr_o` carries `vid_addr_i` outside phase 2 and `cpu_addr_i` during phase 2.
- R4: `ram_cs_o` is high for all of phase 1, which is the video fetch. In phase 2 it is high only when the processor address is in the RAM region (addresses with bit 15 clear). It is low in reset.
- R5: `ram_we_o` is high only when `cpu_we_i` is 1, the address is in the RAM region and phase 2 is active. It is low on the last master clock of phase 2.
- R6: On the last master clock of phase 1, `ram_rdata_i` is latched into `vid_data_o`. `vid_valid_o` pulses for exactly the first master clock of phase 2, and `vid_data_o` holds its value until the next latch.
- R7: `rom_cs_o` is decoded from the processor address alone (bits 15:14 equal to 11, addresses C000 to FFFF) and does not depend on phase.
- R8: `io_cs_o` is high for processor addresses B000 to BFFF (bits 15:12 equal to 1011), independent of phase.
- R9: `cpu_rdata_o` returns `ram_rdata_i`, `rom_rdata_i` or `io_rdata_i` according to the decoded region. Unmapped addresses (8000 to AFFF) return 8'h0E.
- R10: `ram_wdata_o` carries `cpu_wdata_i` during phase 2 and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, carrier-related |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ntsc_i | input | 1 | Rate strap: 0 selects PAL, 1 selects NTSC |
| phi1_o | output | 1 | Phase 1, video half of the cycle |
| phi2_o | output | 1 | Phase 2, processor half of the cycle |
| vid_addr_i | input | 16 | Video fetch address |
| vid_data_o | output | 8 | Latched video fetch byte |
| vid_valid_o | output | 1 | One-clock pulse when new video data is latched |
| cpu_addr_i | input | 16 | Processor address |
| cpu_we_i | input | 1 | Processor write request |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Read data returned to the processor |
| ram_addr_o | output | 16 | Shared RAM address |
| ram_cs_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 8 | RAM write data bus |
| ram_rdata_i | input | 8 | RAM read data |
| rom_cs_o | output | 1 | ROM select |
| rom_rdata_i | input | 8 | ROM read data |
| io_cs_o | output | 1 | I/O select |
| io_rdata_i | input | 8 | I/O read data |

## Verification
The bench walks the processor address through a stride pattern and also places it on every region edge (7FFF/8000, AFFF/B000, BFFF/C000, 0000, FFFF). This separates the four decode results and the read-mux priority. The write request and the write data change with the step, so enable gating and bus blanking are seen with both request values in every phase position. The strap is held long enough to run many whole cycles in each rate, and it is toggled at arbitrary positions inside a cycle. This shows that the length changes only at the next boundary. Video addresses change on every cycle, and the RAM model returns an address-derived byte, so a latch made one clock early or late, or from the processor address, shows up as a wrong byte.

// File: rtl/mi_pkg.sv
package mi_pkg;
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2,
    REG_IO   = 2'd3
  } region_e;
endpackage

// File: rtl/mi_phase_gen.sv
module mi_phase_gen #(
  parameter int HALF_PAL  = 5,
  parameter int HALF_NTSC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ntsc_i,
  output logic phi1_o,
  output logic phi2_o,
  output logic we_win_o,
  output logic latch_o
);
  localparam int MAX_HALF = (HALF_PAL > HALF_NTSC) ? HALF_PAL : HALF_NTSC;
  localparam int CW       = $clog2(2 * MAX_HALF + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q, half_q, last;

  assign last = (half_q << 1) - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= CW'(HALF_PAL);
    end else if (!run_q || cnt_q == last) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      half_q <= ntsc_i ? CW'(HALF_NTSC) : CW'(HALF_PAL);
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign phi1_o   = run_q && (cnt_q < half_q);
  assign phi2_o   = run_q && (cnt_q >= half_q);
  assign we_win_o = phi2_o && (cnt_q != last);
  assign latch_o  = run_q && (cnt_q == half_q - CW'(1));
endmodule

// File: rtl/mi_addr_decode.sv
module mi_addr_decode
  import mi_pkg::*;
#(
  parameter int              AW       = 16,
  parameter logic [AW-1:0]   RAM_MASK = 16'h8000,
  parameter logic [AW-1:0]   RAM_BASE = 16'h0000,
  parameter logic [AW-1:0]   ROM_MASK = 16'hC000,
  parameter logic [AW-1:0]   ROM_BASE = 16'hC000,
  parameter logic [AW-1:0]   IO_MASK  = 16'hF000,
  parameter logic [AW-1:0]   IO_BASE  = 16'hB000
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o
);
  // mask bits clear = don't care; no unknowns enter the compare
  logic ram_hit, rom_hit, io_hit;
  assign ram_hit = (addr_i & RAM_MASK) == RAM_BASE;
  assign rom_hit = (addr_i & ROM_MASK) == ROM_BASE;
  assign io_hit  = (addr_i & IO_MASK)  == IO_BASE;

  always_comb begin
    if (ram_hit)      region_o = REG_RAM;
    else if (rom_hit) region_o = REG_ROM;
    else if (io_hit)  region_o = REG_IO;
    else              region_o = REG_NONE;
  end
endmodule

// File: rtl/mi_read_mux.sv
module mi_read_mux
  import mi_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] OPEN_BUS = 8'h0E
) (
  input  region_e       region_i,
  input  logic [DW-1:0] ram_i,
  input  logic [DW-1:0] rom_i,
  input  logic [DW-1:0] io_i,
  output logic [DW-1:0] data_o
);
  always_comb begin
    unique case (region_i)
      REG_RAM: data_o = ram_i;
      REG_ROM: data_o = rom_i;
      REG_IO:  data_o = io_i;
      default: data_o = OPEN_BUS;
    endcase
  end
endmodule

// File: rtl/mem_interleave.sv
module mem_interleave
  import mi_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 8,
  parameter int            HALF_PAL  = 5,
  parameter int            HALF_NTSC = 4,
  parameter logic [DW-1:0] OPEN_BUS  = 8'h0E
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ntsc_i,
  output logic          phi1_o,
  output logic          phi2_o,
  input  logic [AW-1:0] vid_addr_i,
  output logic [DW-1:0] vid_data_o,
  output logic          vid_valid_o,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_cs_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          rom_cs_o,
  input  logic [DW-1:0] rom_rdata_i,
  output logic          io_cs_o,
  input  logic [DW-1:0] io_rdata_i
);
  logic    phi1, phi2, we_win, latch;
  region_e region;
  logic [DW-1:0] vid_data_q;
  logic          vid_valid_q;

  mi_phase_gen #(.HALF_PAL(HALF_PAL), .HALF_NTSC(HALF_NTSC)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ntsc_i(ntsc_i),
    .phi1_o(phi1), .phi2_o(phi2), .we_win_o(we_win), .latch_o(latch)
  );

  mi_addr_decode #(.AW(AW)) u_dec (
    .addr_i(cpu_addr_i), .region_o(region)
  );

  mi_read_mux #(.DW(DW), .OPEN_BUS(OPEN_BUS)) u_rmux (
    .region_i(region), .ram_i(ram_rdata_i), .rom_i(rom_rdata_i),
    .io_i(io_rdata_i), .data_o(cpu_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_data_q  <= '0;
      vid_valid_q <= 1'b0;
    end else begin
      vid_valid_q <= latch;
      if (latch) vid_data_q <= ram_rdata_i;
    end
  end

  assign phi1_o      = phi1;
  assign phi2_o      = phi2;
  assign vid_data_o  = vid_data_q;
  assign vid_valid_o = vid_valid_q;
  assign ram_addr_o  = phi2 ? cpu_addr_i : vid_addr_i;
  assign ram_cs_o    = phi1 || (phi2 && region == REG_RAM);
  assign ram_we_o    = we_win && cpu_we_i && region == REG_RAM;
  assign ram_wdata_o = phi2 ? cpu_wdata_i : '0;
  assign rom_cs_o    = region == REG_ROM;
  assign io_cs_o     = region == REG_IO;
endmodule

// File: rtl/mem_interleave_chk.sv
module mem_interleave_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          phi1_o,
  input logic          phi2_o,
  input logic          vid_valid_o,
  input logic [AW-1:0] vid_addr_i,
  input logic [AW-1:0] ram_addr_o,
  input logic          ram_cs_o,
  input logic          ram_we_o,
  input logic          rom_cs_o,
  input logic          io_cs_o
);
  assert_phase_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phi1_o && phi2_o));
  assert_phase_cont_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi1_o || phi2_o) |=> (phi1_o || phi2_o));
  assert_vid_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phi1_o |-> ram_addr_o == vid_addr_i);
  assert_cs_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2_o && ram_cs_o) |-> !(rom_cs_o || io_cs_o));
  assert_we_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (phi2_o && ram_cs_o));
  assert_we_early_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> phi2_o);
  assert_vid_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_valid_o |-> (phi2_o && $past(phi1_o)));
endmodule

bind mem_interleave mem_interleave_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .phi1_o(phi1_o), .phi2_o(phi2_o),
  .vid_valid_o(vid_valid_o), .vid_addr_i(vid_addr_i), .ram_addr_o(ram_addr_o),
  .ram_cs_o(ram_cs_o), .ram_we_o(ram_we_o), .rom_cs_o(rom_cs_o), .io_cs_o(io_cs_o)
);

// File: tb/mem_interleave_tb_top.sv
`timescale 1ns/1ps
module mem_interleave_tb_top;
  localparam int HP = 5;
  localparam int HN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ntsc = 1'b0;
  logic        phi1, phi2, vid_valid, cpu_we, ram_cs, ram_we, rom_cs, io_cs;
  logic [15:0] vid_addr = '0, cpu_addr = '0, ram_addr;
  logic [7:0]  vid_data, cpu_wdata = '0, cpu_rdata, ram_wdata, ram_rdata, rom_rdata, io_rdata;

  int n_vec = 0;
  int n_err = 0;
  int pos   = -1;
  int half  = HP;
  logic [7:0] exp_vid = '0;

  always #10 clk = ~clk;

  mem_interleave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ntsc_i(ntsc), .phi1_o(phi1), .phi2_o(phi2),
    .vid_addr_i(vid_addr), .vid_data_o(vid_data), .vid_valid_o(vid_valid),
    .cpu_addr_i(cpu_addr), .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .ram_addr_o(ram_addr), .ram_cs_o(ram_cs),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .rom_cs_o(rom_cs), .rom_rdata_i(rom_rdata), .io_cs_o(io_cs), .io_rdata_i(io_rdata)
  );

  function automatic logic [7:0] ram_f(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign ram_rdata = ram_f(ram_addr);
  assign rom_rdata = cpu_addr[7:0] + 8'h33;
  assign io_rdata  = cpu_addr[15:8] ^ 8'hC3;

  // 0 none, 1 ram, 2 rom, 3 io
  function automatic int region(logic [15:0] a);
    if (!a[15])              return 1;
    if (a[15:14] == 2'b11)   return 2;
    if (a[15:12] == 4'hB)    return 3;
    return 0;
  endfunction

  // model of cycle position, per R1
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= -1;
      half <= HP;
    end else if (pos < 0 || pos == 2 * half - 1) begin
      pos  <= 0;
      half <= ntsc ? HN : HP;
    end else begin
      pos  <= pos + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, pos, act, exp);
    end
  endtask

  task automatic check_all();
    bit e1, e2, hit;
    int r;
    logic [15:0] ea;
    logic [7:0]  er;
    e1  = (pos >= 0) && (pos < half);
    e2  = (pos >= half);
    r   = region(cpu_addr);
    hit = (r == 1);
    chk(phi1 == e1, "R1 R2 phi1", 32'(phi1), 32'(e1));
    chk(phi2 == e2, "R1 R2 phi2", 32'(phi2), 32'(e2));
    ea = e2 ? cpu_addr : vid_addr;
    chk(ram_addr == ea, "R3 ram_addr", 32'(ram_addr), 32'(ea));
    chk(ram_cs == (e1 || (e2 && hit)), "R4 ram_cs", 32'(ram_cs), 32'(e1 || (e2 && hit)));
    chk(ram_we == (cpu_we && hit && e2 && pos < 2 * half - 1), "R5 ram_we",
        32'(ram_we), 32'(cpu_we && hit && e2 && pos < 2 * half - 1));
    chk(vid_valid == (pos == half), "R6 vid_valid", 32'(vid_valid), 32'(pos == half));
    chk(vid_data == exp_vid, "R6 vid_data", 32'(vid_data), 32'(exp_vid));
    chk(rom_cs == (r == 2), "R7 rom_cs", 32'(rom_cs), 32'(r == 2));
    chk(io_cs == (r == 3), "R8 io_cs", 32'(io_cs), 32'(r == 3));
    case (r)
      1:       er = ram_f(ea);
      2:       er = cpu_addr[7:0] + 8'h33;
      3:       er = cpu_addr[15:8] ^ 8'hC3;
      default: er = 8'h0E;
    endcase
    chk(cpu_rdata == er, "R9 cpu_rdata", 32'(cpu_rdata), 32'(er));
    chk(ram_wdata == (e2 ? cpu_wdata : 8'h00), "R10 ram_wdata",
        32'(ram_wdata), 32'(e2 ? cpu_wdata : 8'h00));
    if (pos == half - 1) exp_vid = ram_f(vid_addr);
  endtask

  localparam logic [15:0] BND [12] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hAFFF,
    16'hB000, 16'hBFFF, 16'hC000, 16'hFFFF, 16'h9ABC, 16'hB7F0, 16'h4000, 16'hDEAD};

  initial begin
    // reset state, R2 R4 R5 R6
    for (int i = 0; i < 4; i++) begin
      cpu_addr = BND[i];
      cpu_we   = 1'b1;
      @(negedge clk);
      chk(!phi1 && !phi2, "R2 reset phases", 32'({phi1, phi2}), 32'(0));
      chk(!ram_cs && !ram_we && !vid_valid, "R4 R5 reset selects",
          32'({ram_cs, ram_we, vid_valid}), 32'(0));
    end
    rst_n = 1'b1;
    for (int j = 0; j < 6000; j++) begin
      @(negedge clk);
      check_all();
      ntsc      = ((j / 701) % 2) == 1;
      cpu_addr  = (j % 5 == 0) ? BND[(j / 5) % 12] : 16'(j * 16'h0B3D + 16'h0111);
      cpu_we    = ((j / 3) % 2) == 1;
      cpu_wdata = 8'(j * 7 + 1);
      if (pos < 0 || pos >= half) vid_addr = 16'(j * 16'h0269 + 16'h0101);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #3_000_000;
    n_err++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule